// File: doc/BRIEF.md
# Flash erase and program engine with boot-region lockout

This block carries out the write-type operations of a parallel NOR-style flash model once a command decoder has recognised them: byte program, sector erase, whole-array erase, and the one-way boot-region lockout. It holds the storage as a plain register array so that the whole device can be simulated. It times each operation internally with a cycle counter, so the caller only issues a single-cycle request and then watches the busy flag.

Programming can only turn ones into zeros. Erasing works over an uneven sector map that is scaled to the array size. Once the lockout flag is set, the lowest sector is silently excluded from both programming and erasing. A rejected or excluded operation still behaves the same at the status outputs, which lets polling logic work without special cases. The lockout flag keeps its value across the block's reset unless a parameter says otherwise, which models non-volatile retention. The status logic uses the busy flag, the operation code and the captured address and data of the last program request.

Top module: `flash_op_engine`

## Requirements
- R1: The array starts as all bytes FFh and the lock flag starts clear. During and after reset, `busy` is 0 and `op_kind` is 0.
- R2: A program request stores the old byte ANDed with `req_data` at `req_addr`. The array is unchanged while the operation is busy, and the new value is readable once `busy` has fallen.
- R3: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0. Op codes are 1 for program, 2 for sector erase, 3 for chip erase and 4 for lockout. From the next cycle, `busy` is 1 and `op_kind` holds the code for exactly T_BP, T_SE or T_EC cycles.
- R4: A request made while `busy` is 1 has no effect. It does not change `op_kind`, the array, `last_addr`, `last_data` or the lock flag.
- R5: A sector erase sets to FFh every byte of the sector that holds `req_addr`, and no other byte. With the array size written N, the sectors are: the boot region [0, N/32); two parameter sectors [N/32, 3N/64) and [3N/64, N/16); a first main sector [N/16, N/8); and seven main sectors of N/8 each. For N=1024 these are 0-31, 32-47, 48-63, 64-127, then 128-byte blocks.
- R6: A chip erase sets every byte to FFh. When the lock flag is set, the boot region keeps its content.
- R7: A lockout request sets `lock_on` in the next cycle and never asserts `busy`. A repeated lockout request leaves `lock_on` set. While `lock_on` is 1, program and sector-erase requests that target the boot region still hold `busy` for their full time but change no byte.
- R8: On taking a program request, `last_addr` and `last_data` load `req_addr` and `req_data`. Both hold their values until the next program request is taken.
- R9: With LOCK_CLR_ON_RST=0, asserting `rst_n` low leaves both `lock_on` and the array contents unchanged.
- R10: When the timed operation ends, `busy` returns to 0 and `op_kind` returns to 0 without any further input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencing state |
| req_valid | input | 1 | Request strobe from the command decoder |
| req_op | input | 3 | Operation code: 1 program, 2 sector erase, 3 chip erase, 4 lockout |
| req_addr | input | AW | Byte address of the program target, or an address inside the sector to erase |
| req_data | input | DW | Data to program |
| rd_addr | input | AW | Read address into the array |
| rd_data | output | DW | Array byte at rd_addr (combinational) |
| busy | output | 1 | Timed operation in progress |
| op_kind | output | 3 | Code of the running operation, 0 when idle |
| last_addr | output | AW | Address of the last program request taken |
| last_data | output | DW | Data of the last program request taken |
| lock_on | output | 1 | Boot-region lockout active |

## Verification
A request the block takes on edge e shows `busy` and `op_kind` one edge later. The array update, the fall of `busy` and the clearing of `op_kind` all appear after edge e+T. The lock flag and the captured program address and data appear one edge after the request. The bench drives inputs on falling edges and checks `busy`/`op_kind` on the first falling edge after the request. It then counts the falling edges at which `busy` is high and compares that count with T. It reads the array only after `busy` is low, and it also probes the target byte once while the operation is still running.

// File: rtl/flash_op_engine.sv
module flash_op_engine #(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int T_BP = 4,
  parameter int T_SE = 16,
  parameter int T_EC = 32,
  parameter bit LOCK_CLR_ON_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] last_addr,
  output logic [DW-1:0] last_data,
  output logic          lock_on
);
  localparam int DEPTH = 1 << AW;
  localparam int UNIT  = DEPTH / 64;
  localparam int TMAX  = (T_EC > T_SE) ? ((T_EC > T_BP) ? T_EC : T_BP)
                                       : ((T_SE > T_BP) ? T_SE : T_BP);
  localparam int CW    = $clog2(TMAX + 1);
  localparam logic [AW-1:0] BOOT_END = AW'(2 * UNIT);
  localparam logic [AW-1:0] PAR1_END = AW'(3 * UNIT);
  localparam logic [AW-1:0] PAR2_END = AW'(4 * UNIT);
  localparam logic [AW-1:0] MAIN_END = AW'(8 * UNIT);
  localparam logic [2:0] OP_PROG = 3'd1;
  localparam logic [2:0] OP_SERA = 3'd2;
  localparam logic [2:0] OP_CERA = 3'd3;
  localparam logic [2:0] OP_LOCK = 3'd4;

  function automatic logic [3:0] sector_of(input logic [AW-1:0] a);
    if (a < BOOT_END)      return 4'd0;
    else if (a < PAR1_END) return 4'd1;
    else if (a < PAR2_END) return 4'd2;
    else if (a < MAIN_END) return 4'd3;
    else                   return 4'd3 + {1'b0, a[AW-1 -: 3]};
  endfunction

  logic [DW-1:0] mem [DEPTH] = '{default: '1};
  logic          lock_q = 1'b0;
  logic          busy_q;
  logic [2:0]    op_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] tgt_addr_q;
  logic [DW-1:0] tgt_data_q;
  logic [AW-1:0] last_addr_q;
  logic [DW-1:0] last_data_q;

  wire idle_take = req_valid && !busy_q;
  wire start     = idle_take && (req_op inside {OP_PROG, OP_SERA, OP_CERA});
  wire finish    = rst_n && busy_q && (cnt_q == '0);
  wire [3:0] tgt_sec = sector_of(tgt_addr_q);
  wire tgt_guard = lock_q && (tgt_sec == 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      op_q        <= '0;
      cnt_q       <= '0;
      tgt_addr_q  <= '0;
      tgt_data_q  <= '0;
      last_addr_q <= '0;
      last_data_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q     <= 1'b1;
        op_q       <= req_op;
        tgt_addr_q <= req_addr;
        tgt_data_q <= req_data;
        case (req_op)
          OP_PROG: cnt_q <= CW'(T_BP - 1);
          OP_SERA: cnt_q <= CW'(T_SE - 1);
          default: cnt_q <= CW'(T_EC - 1);
        endcase
        if (req_op == OP_PROG) begin
          last_addr_q <= req_addr;
          last_data_q <= req_data;
        end
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
      op_q   <= '0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (LOCK_CLR_ON_RST) lock_q <= 1'b0;
    end else if (idle_take && req_op == OP_LOCK) begin
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      case (op_q)
        OP_PROG: if (!tgt_guard) mem[tgt_addr_q] <= mem[tgt_addr_q] & tgt_data_q;
        OP_SERA: begin
          for (int i = 0; i < DEPTH; i++)
            if (!tgt_guard && sector_of(AW'(i)) == tgt_sec) mem[i] <= '1;
        end
        OP_CERA: begin
          for (int i = 0; i < DEPTH; i++)
            if (!(lock_q && sector_of(AW'(i)) == 4'd0)) mem[i] <= '1;
        end
        default: ;
      endcase
    end
  end

  assign rd_data   = mem[rd_addr];
  assign busy      = busy_q;
  assign op_kind   = op_q;
  assign last_addr = last_addr_q;
  assign last_data = last_data_q;
  assign lock_on   = lock_q;
endmodule

// File: rtl/flash_op_engine_chk.sv
module flash_op_engine_chk #(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int T_BP = 4,
  parameter int T_SE = 16,
  parameter int T_EC = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_data,
  input logic          busy,
  input logic [2:0]    op_kind,
  input logic [AW-1:0] last_addr,
  input logic [DW-1:0] last_data,
  input logic          lock_on
);
  logic [15:0] blen;
  logic [2:0]  lop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blen <= '0;
      lop  <= '0;
    end else begin
      blen <= busy ? blen + 16'd1 : 16'd0;
      if (busy) lop <= op_kind;
    end
  end

  function automatic logic [15:0] want_len(input logic [2:0] op);
    case (op)
      3'd1:    return 16'(T_BP);
      3'd2:    return 16'(T_SE);
      default: return 16'(T_EC);
    endcase
  endfunction

  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && (req_op inside {3'd1, 3'd2, 3'd3})) |=> (busy && op_kind == $past(req_op)));

  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(busy)) |-> (blen == want_len(lop)));

  a_r4_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || op_kind == $past(op_kind)));

  a_r4_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(last_addr) && $stable(last_data)));

  a_r8_last_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op == 3'd1) |=> (last_addr == $past(req_addr) && last_data == $past(req_data)));

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_on |=> lock_on);

  a_r7_lock_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op == 3'd4) |=> (lock_on && !busy));

  a_r10_idle_op: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (op_kind == 3'd0));
endmodule

bind flash_op_engine flash_op_engine_chk #(
  .AW(AW), .DW(DW), .T_BP(T_BP), .T_SE(T_SE), .T_EC(T_EC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_data(req_data), .busy(busy), .op_kind(op_kind),
  .last_addr(last_addr), .last_data(last_data), .lock_on(lock_on)
);

// File: tb/flash_op_engine_bench.sv
`timescale 1ns/1ps
module flash_op_engine_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1024;
  localparam int TBP = 4, TSE = 16, TEC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, lock_on;
  logic [2:0] op_kind;
  logic [AW-1:0] last_addr;
  logic [7:0] last_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] bm [DEPTH];
  logic mlock = 1'b0;

  always #2.5 clk = ~clk;

  flash_op_engine u_flash_op_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .op_kind(op_kind), .last_addr(last_addr), .last_data(last_data),
    .lock_on(lock_on)
  );

  function automatic int sec(input int a);
    if (a < 32) return 0;
    if (a < 48) return 1;
    if (a < 64) return 2;
    if (a < 128) return 3;
    return 3 + a / 128;
  endfunction

  function automatic int tlen(input logic [2:0] op);
    return (op == 3'd1) ? TBP : (op == 3'd2) ? TSE : TEC;
  endfunction

  function automatic void apply(input logic [2:0] op, input int a, input logic [7:0] d);
    if (op == 3'd1) begin
      if (!(mlock && sec(a) == 0)) bm[a] = bm[a] & d;
    end else if (op == 3'd2) begin
      int s = sec(a);
      if (!(mlock && s == 0))
        for (int i = 0; i < DEPTH; i++) if (sec(i) == s) bm[i] = 8'hFF;
    end else if (op == 3'd3) begin
      for (int i = 0; i < DEPTH; i++) if (!(mlock && sec(i) == 0)) bm[i] = 8'hFF;
    end
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_array(input string tag);
    int bad = -1;
    logic [7:0] got = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i);
      #0.2;
      if (bad < 0 && rd_data !== bm[i]) begin
        bad = i;
        got = rd_data;
      end
    end
    check(bad < 0, tag, (bad < 0) ? 0 : {bad, got}, (bad < 0) ? 0 : {bad, bm[bad]});
  endtask

  task automatic drive(input logic [2:0] op, input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input int a, input logic [7:0] d, input string tag);
    int n;
    drive(op, a, d);
    check(busy === 1'b1 && op_kind === op, {"R3 start ", tag}, {busy, op_kind}, {1'b1, op});
    rd_addr = AW'(a);
    #0.2;
    check(rd_data === bm[a], {"R2 array unchanged while busy ", tag}, rd_data, bm[a]);
    n = 1;
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
    check(n == tlen(op), {"R3 busy length ", tag}, n, tlen(op));
    check(op_kind === 3'd0, {"R10 op_kind idle ", tag}, op_kind, 0);
    apply(op, a, d);
    check_array({"R2 R5 R6 array after ", tag});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < DEPTH; i++) bm[i] = 8'hFF;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && op_kind === 3'd0 && lock_on === 1'b0, "R1 state in reset", {busy, op_kind, lock_on}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && op_kind === 3'd0, "R1 idle after reset", {busy, op_kind}, 0);
    check_array("R1 array blank");

    run_op(3'd1, 200, 8'h5A, "prog1");
    check(last_addr === AW'(200) && last_data === 8'h5A, "R8 last capture", {last_addr, last_data}, {10'd200, 8'h5A});
    run_op(3'd1, 200, 8'hF0, "prog AND");
    rd_addr = AW'(200); #0.2;
    check(rd_data === 8'h50, "R2 and-merge", rd_data, 8'h50);

    drive(3'd1, 300, 8'h0F);
    req_valid = 1'b1; req_op = 3'd2; req_addr = AW'(310); req_data = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    check(op_kind === 3'd1, "R4 op unchanged by busy request", op_kind, 1);
    check(lock_on === 1'b0, "R4 lock request ignored while busy", lock_on, 0);
    while (busy) @(negedge clk);
    apply(3'd1, 300, 8'h0F);
    check(last_addr === AW'(300) && last_data === 8'h0F, "R4 last hold", {last_addr, last_data}, {10'd300, 8'h0F});
    check_array("R4 array only first op");

    run_op(3'd1, 33, 8'h11, "p1 prog");
    run_op(3'd1, 47, 8'h22, "p1 top");
    run_op(3'd1, 48, 8'h33, "p2 prog");
    run_op(3'd1, 31, 8'h44, "boot prog");
    run_op(3'd2, 40, 8'h00, "erase p1");
    rd_addr = AW'(48); #0.2;
    check(rd_data === 8'h33, "R5 neighbour sector kept", rd_data, 8'h33);
    rd_addr = AW'(47); #0.2;
    check(rd_data === 8'hFF, "R5 sector erased", rd_data, 8'hFF);

    for (int k = 0; k < 40; k++) begin
      int a = $urandom % DEPTH;
      logic [2:0] op = (($urandom % 4) == 3) ? 3'd2 : 3'd1;
      run_op(op, a, 8'($urandom), "random");
    end

    run_op(3'd3, 0, 8'h00, "chip erase unlocked");
    run_op(3'd1, 5, 8'hA5, "boot pre-lock");
    run_op(3'd1, 500, 8'h3C, "main pre-lock");

    drive(3'd4, 0, 8'h00);
    check(lock_on === 1'b1 && busy === 1'b0, "R7 lock set no busy", {lock_on, busy}, 2'b10);
    mlock = 1'b1;
    drive(3'd4, 0, 8'h00);
    check(lock_on === 1'b1 && busy === 1'b0, "R7 repeat lock", {lock_on, busy}, 2'b10);

    run_op(3'd1, 5, 8'h00, "R7 locked boot program");
    run_op(3'd2, 10, 8'h00, "R7 locked boot erase");
    run_op(3'd1, 600, 8'h0F, "R7 unlocked main program");
    run_op(3'd3, 0, 8'h00, "R6 chip erase locked");
    rd_addr = AW'(5); #0.2;
    check(rd_data === 8'hA5, "R6 boot kept under lock", rd_data, 8'hA5);

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lock_on === 1'b1, "R9 lock survives reset", lock_on, 1);
    check(busy === 1'b0 && op_kind === 3'd0, "R1 idle after second reset", {busy, op_kind}, 0);
    check_array("R9 array survives reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule